// File: doc/BRIEF.md
# Address Register Arithmetic Unit

This unit performs the arithmetic and comparison steps that a processor applies to address registers. It can load an immediate into the upper half of a word, add an immediate to the upper half, add a sign-extended 16-bit offset, and add a data index scaled by the element size. It also compares two addresses and returns a word that holds 0 or 1. Any 32-bit constant can be built in two operations. The first loads the upper half, rounded up by 8000h. The second adds the lower half as a signed offset.

An operation is presented together with `in_valid` and is captured on the next rising clock edge. The result appears on `result` with `out_valid` high for one cycle. When no operation is presented, the last result is held. Memory access, the register file and instruction fetch are handled elsewhere.

Top module: `addr_arith_unit`

## Requirements
- R1: Operation code 0 (load-high) gives `imm` in bits 31:16 and zeros in bits 15:0. `addr_a` and `opnd_b` have no effect.
- R2: Operation code 1 (add-high) gives `addr_a + (imm << 16)`, wrapping modulo 2^32.
- R3: Operation code 2 (offset add) gives `addr_a` plus `imm` sign-extended from bit 15, wrapping modulo 2^32.
- R4: Operation code 3 (scaled add) gives `addr_a + (opnd_b << scale)`, wrapping modulo 2^32. Scale values 0, 1, 2 and 3 select byte, half-word, word and double-word elements.
- R5: Operation code 4 (less-than) gives 1 when `addr_a` is below `opnd_b` as unsigned numbers, and 0 otherwise. Bits 31:1 of the result are zero.
- R6: Operation code 5 (equal) gives 1 when the operands match. Operation code 6 (not-equal) gives 1 when they differ. For both, bits 31:1 of the result are zero.
- R7: Operation code 7 is reserved and gives a result of 0.
- R8: An operation accepted on a rising edge with `in_valid` high shows on `result` after that edge, and `out_valid` is high for that cycle. After an edge with `in_valid` low, `out_valid` is low and `result` is unchanged.
- R9: After reset, `result` is 0 and `out_valid` is 0.
- R10: A load-high of `(K + 8000h) >> 16`, followed by an offset add of `K[15:0]` to that result, yields K exactly for every 32-bit K. This includes values of K whose bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (0 to 7) |
| addr_a | input | 32 | Address operand |
| opnd_b | input | 32 | Second address, or data index |
| imm | input | 16 | Immediate value |
| scale | input | 2 | Shift applied to the index in the scaled add |
| out_valid | output | 1 | The result register was loaded on the last edge |
| result | output | 32 | Address result or 0/1 compare word |

## Verification
The result is a single register one stage behind the inputs, so a wrong value shows on `result` in the first cycle after the operation is accepted. A mistake in sign extension shows up only when the offset has bit 15 set. A mistake in carry into the upper half shows up only when the low-half sum overflows. For these reasons the sweeps include operands at those boundaries. A wrong select in the compare stage shows as a 1 in an upper bit, or as a flipped bit 0, on the very next output. A hold fault shows as a changed `result` during an idle cycle.

// File: rtl/addr_arith_pkg.sv
package addr_arith_pkg;
   typedef enum logic [2:0] {
      AOP_LOAD_HI = 3'd0,
      AOP_ADD_HI  = 3'd1,
      AOP_ADD_OFS = 3'd2,
      AOP_ADD_SCL = 3'd3,
      AOP_CMP_LTU = 3'd4,
      AOP_CMP_EQ  = 3'd5,
      AOP_CMP_NE  = 3'd6,
      AOP_RSVD    = 3'd7
   } aop_e;

   function automatic logic is_compare(input aop_e o);
      return (o == AOP_CMP_LTU) || (o == AOP_CMP_EQ) || (o == AOP_CMP_NE);
   endfunction
endpackage

// File: rtl/addr_arith_adder.sv
module addr_arith_adder
   import addr_arith_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int IMM_W   = 16,
   parameter int SCALE_W = 2
) (
   input  aop_e               op,
   input  logic [ADDR_W-1:0]  addr_a,
   input  logic [ADDR_W-1:0]  opnd_b,
   input  logic [IMM_W-1:0]   imm,
   input  logic [SCALE_W-1:0] scale,
   output logic [ADDR_W-1:0]  sum
);
   localparam int EXT_W = ADDR_W - IMM_W;

   generate
      if (EXT_W < 1) begin : g_bad_width
         $error("addr_arith_adder: IMM_W must be below ADDR_W");
      end
      if ((1 << SCALE_W) > ADDR_W) begin : g_bad_scale
         $error("addr_arith_adder: SCALE_W too wide for ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] hi_imm;
   logic [ADDR_W-1:0] sext_imm;
   logic [ADDR_W-1:0] scaled_b;
   logic [ADDR_W-1:0] addend;

   always_comb begin
      hi_imm   = {imm, {EXT_W{1'b0}}};
      sext_imm = {{EXT_W{imm[IMM_W-1]}}, imm};
      scaled_b = opnd_b << scale;
      unique case (op)
         AOP_ADD_HI:  addend = hi_imm;
         AOP_ADD_OFS: addend = sext_imm;
         AOP_ADD_SCL: addend = scaled_b;
         default:     addend = '0;
      endcase
      if (op == AOP_LOAD_HI) sum = hi_imm;
      else                   sum = addr_a + addend;
   end
endmodule

// File: rtl/addr_arith_compare.sv
module addr_arith_compare
   import addr_arith_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit SIGNED_LT = 1'b0
) (
   input  aop_e              op,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] opnd_b,
   output logic [ADDR_W-1:0] flag_word
);
   logic lt_bit;

   generate
      if (SIGNED_LT) begin : g_lt_signed
         assign lt_bit = $signed(addr_a) < $signed(opnd_b);
      end else begin : g_lt_unsigned
         assign lt_bit = addr_a < opnd_b;
      end
   endgenerate

   logic eq_bit;
   logic flag;
   assign eq_bit = (addr_a == opnd_b);

   always_comb begin
      unique case (op)
         AOP_CMP_LTU: flag = lt_bit;
         AOP_CMP_EQ:  flag = eq_bit;
         AOP_CMP_NE:  flag = ~eq_bit;
         default:     flag = 1'b0;
      endcase
      flag_word    = '0;
      flag_word[0] = flag;
   end
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
   import addr_arith_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IMM_W     = 16,
   parameter int SCALE_W   = 2,
   parameter bit SIGNED_LT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2:0]         op,
   input  logic [ADDR_W-1:0]  addr_a,
   input  logic [ADDR_W-1:0]  opnd_b,
   input  logic [IMM_W-1:0]   imm,
   input  logic [SCALE_W-1:0] scale,
   output logic               out_valid,
   output logic [ADDR_W-1:0]  result
);
   aop_e              op_e;
   logic [ADDR_W-1:0] sum_w;
   logic [ADDR_W-1:0] cmp_w;
   logic [ADDR_W-1:0] next_w;

   assign op_e = aop_e'(op);

   addr_arith_adder #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SCALE_W(SCALE_W)) u_add (
      .op(op_e), .addr_a(addr_a), .opnd_b(opnd_b), .imm(imm), .scale(scale), .sum(sum_w)
   );

   addr_arith_compare #(.ADDR_W(ADDR_W), .SIGNED_LT(SIGNED_LT)) u_cmp (
      .op(op_e), .addr_a(addr_a), .opnd_b(opnd_b), .flag_word(cmp_w)
   );

   always_comb begin
      if (op_e == AOP_RSVD)      next_w = '0;
      else if (is_compare(op_e)) next_w = cmp_w;
      else                       next_w = sum_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_w;
      end
   end

   assert_ldhi_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd0) |=> (result[ADDR_W-IMM_W-1:0] == '0));

   assert_addsc_unscaled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd3 && scale == '0) |=> (result == $past(addr_a + opnd_b)));

   assert_cmp_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == 3'd4 || op == 3'd5 || op == 3'd6)) |=> (result[ADDR_W-1:1] == '0));

   assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd7) |=> (result == '0));

   assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));
endmodule

// File: tb/sim_addr_arith_unit.sv
module sim_addr_arith_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] addr_a = '0;
   logic [31:0] opnd_b = '0;
   logic [15:0] imm = '0;
   logic [1:0]  scale = '0;
   logic        out_valid;
   logic [31:0] result;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   addr_arith_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .addr_a(addr_a),
      .opnd_b(opnd_b), .imm(imm), .scale(scale), .out_valid(out_valid), .result(result)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // drive on falling edge, capture on rising edge, sample on next falling edge
   task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i, input logic [1:0] s,
                         input logic [31:0] exp, input string req);
      op = o; addr_a = a; opnd_b = b; imm = i; scale = s; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(req, result, exp);
      check({req, " valid"}, {31'd0, out_valid}, 32'd1);
   endtask

   function automatic logic [31:0] pat(input int k);
      logic [31:0] v;
      v = k[3] ? (32'hFFFF_FFF8 + 32'(k[2:0])) : 32'(k[2:0]);
      return v;
   endfunction

   initial begin : watchdog
      #3000000;
      fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] k, hi_res, held;
      logic [15:0] hi;
      @(negedge clk);
      // R9 reset state
      check("R9 result", result, 32'd0);
      check("R9 valid", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 load-high, addr_a and opnd_b ignored
      for (int n = 0; n < 16; n++) begin
         logic [15:0] iv;
         iv = 16'(n * 16'h1111) ^ 16'h8001;
         run_op(3'd0, $urandom, $urandom, iv, 2'(n), {iv, 16'h0000}, "R1");
      end

      // R2 add-high with wrap
      for (int n = 0; n < 16; n++) begin
         logic [31:0] a;
         logic [15:0] iv;
         a = (n < 8) ? 32'(n) * 32'h2345_6789 : 32'hFFFF_0000 + 32'(n);
         iv = 16'(n * 16'h3001);
         run_op(3'd1, a, 32'd0, iv, 2'd0, a + {iv, 16'h0}, "R2");
      end

      // R3 offset add, both signs, carry across bit 15
      for (int n = 0; n < 16; n++) begin
         logic [31:0] a;
         logic [15:0] iv;
         a = 32'h0001_7FF0 + 32'(n) * 32'h0800_0003;
         iv = (n % 2 == 1) ? 16'h8000 + 16'(n) : 16'h7FF0 + 16'(n);
         run_op(3'd2, a, 32'd0, iv, 2'd0, a + {{16{iv[15]}}, iv}, "R3");
      end

      // R4 scaled add over all scales and index patterns
      for (int s = 0; s < 4; s++) begin
         for (int n = 0; n < 16; n++) begin
            logic [31:0] a, b;
            a = 32'hFFFF_FFF0 + 32'(n * 3);
            b = pat(n) ^ (32'(n) << 28);
            run_op(3'd3, a, b, 16'hFFFF, 2'(s), a + (b * (32'd1 << s)), "R4");
         end
      end

      // R5, R6 compare sweep over small and near-top values
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            logic [31:0] a, b;
            a = pat(x); b = pat(y);
            run_op(3'd4, a, b, 16'h0, 2'd0, (a < b) ? 32'd1 : 32'd0, "R5");
            run_op(3'd5, a, b, 16'h0, 2'd0, (a == b) ? 32'd1 : 32'd0, "R6 eq");
            run_op(3'd6, a, b, 16'h0, 2'd0, (a != b) ? 32'd1 : 32'd0, "R6 ne");
         end
      end
      run_op(3'd4, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 2'd0, 32'd1, "R5 unsigned");

      // R7 reserved code
      run_op(3'd7, 32'hDEAD_BEEF, 32'h1234_5678, 16'hFFFF, 2'd3, 32'd0, "R7");

      // R8 hold while idle
      run_op(3'd1, 32'h1000_0000, 32'd0, 16'h0001, 2'd0, 32'h1001_0000, "R8 load");
      held = result;
      op = 3'd0; imm = 16'hABCD; addr_a = 32'h5555_5555;
      for (int n = 0; n < 4; n++) begin
         @(negedge clk);
         check("R8 hold", result, held);
         check("R8 idle valid", {31'd0, out_valid}, 32'd0);
      end

      // R10 two-step constant rebuild
      for (int n = 0; n < 400; n++) begin
         k = $urandom;
         if (n < 8) k = {16'(n * 16'h2001), 16'h8000 | 16'(n)};
         if (n == 8) k = 32'hFFFF_FFFF;
         if (n == 9) k = 32'h7FFF_8000;
         hi = 16'((k + 32'h8000) >> 16);
         run_op(3'd0, $urandom, 32'd0, hi, 2'd0, {hi, 16'h0}, "R10 high");
         hi_res = result;
         run_op(3'd2, hi_res, 32'd0, k[15:0], 2'd0, k, "R10 rebuild");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule